// File: doc/BRIEF.md
# Host-Driven Target Memory Loader

This block lets a host that owns an 8-bit parallel port and a handful of control pins fill a target processor's SRAM while the target is parked off its bus. The host asks the target for the bus. Once the target grants it, the host steers the block with a 2-bit mode code. The mode either captures the upper address byte, captures the lower address byte, or writes the byte on the port into SRAM at the held address. The port carries address bytes and data bytes alike. Each value is captured on the clock edge at which its mode is entered, so a whole sector goes in by toggling the mode between low-address load and data write, with the low address advanced each time.

The address registers and the SRAM chip enable are driven only while the target acknowledges the bus. Each tristate pin is modelled as a value plus a shared output enable. When nothing is driven, the value reads as zero and the strobes read inactive. One extra host pin supplies address bit 16 and selects one of two 64 KiB banks. A host reset pin drives the target's reset. After an image load, the host asserts target reset before it drops its bus request, then releases reset so the target starts from address 0.

Top module: `host_sram_loader`

## Requirements
- R1: While `rst_n` is low, and after it, before any load, both address bytes read 0 and `sram_we_n` is 1.
- R2: Entering mode 0 (`mode`=2'b00) while `host_busreq_n` is 0 captures `host_data` into address bits 15:8 at that clock edge.
- R3: Staying in a load mode does not recapture. A change on `host_data` while the mode is held leaves the address unchanged.
- R4: Entering mode 2 (`mode`=2'b10) while enabled gives `sram_we_n`=0 in the next cycle. In that cycle `sram_wdata` is the byte from the entering edge and `sram_addr` is the held address.
- R5: A write strobe lasts exactly one cycle. Holding mode 2 produces no further write.
- R6: Entering mode 1 (`mode`=2'b01) captures `host_data` into address bits 7:0. Alternating modes 1 and 2 writes consecutive bytes at consecutive low addresses.
- R7: While `host_busreq_n` is 1, mode changes neither load an address nor write.
- R8: While `target_busack_n` is 1, `sram_bus_oe` is 0. In that state `sram_addr` and `sram_wdata` read 0 and `sram_ce_n` and `sram_we_n` read 1. While it is 0, `sram_bus_oe` is 1 and `sram_ce_n` is 0.
- R9: `sram_addr[16]` equals `host_bank` whenever the bus is driven.
- R10: Mode 3 (`mode`=2'b11) is unused. Entering it changes no address and writes nothing.
- R11: `target_busreq_n` follows `host_busreq_n`, and `target_reset_n` is the inverse of `host_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_data | input | 8 | Shared address/data byte from the host port |
| mode | input | 2 | Action code: 0 high addr, 1 low addr, 2 write, 3 unused |
| host_busreq_n | input | 1 | Host's active-low bus request; enables the decoder |
| host_bank | input | 1 | Bank select, becomes SRAM address bit 16 |
| host_reset | input | 1 | Host request to hold the target in reset |
| target_busack_n | input | 1 | Target's active-low bus acknowledge |
| target_busreq_n | output | 1 | Bus request to the target |
| target_reset_n | output | 1 | Active-low reset to the target |
| sram_bus_oe | output | 1 | Drive enable for address, data and strobes |
| sram_addr | output | 17 | SRAM address (bank, high, low) |
| sram_wdata | output | 8 | SRAM write data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low |

## Verification
The bench builds the block with its default widths: an 8-bit port, a 16-bit address and one bank bit. At these widths every address byte that is loaded can be seen whole at `sram_addr`, and both banks can be reached. The checks target the sequences where ordering matters. One is a held mode with a changing data byte. Another is the low-address/write toggle across several bytes. Others are mode changes made while the request is withdrawn, and a write attempted after the acknowledge is dropped.

// File: rtl/host_sram_loader.sv
module host_sram_loader #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DATA_W-1:0]             host_data,
  input  logic [1:0]                    mode,
  input  logic                          host_busreq_n,
  input  logic [BANK_W-1:0]             host_bank,
  input  logic                          host_reset,
  input  logic                          target_busack_n,
  output logic                          target_busreq_n,
  output logic                          target_reset_n,
  output logic                          sram_bus_oe,
  output logic [BANK_W+2*DATA_W-1:0]    sram_addr,
  output logic [DATA_W-1:0]             sram_wdata,
  output logic                          sram_ce_n,
  output logic                          sram_we_n
);
  localparam int ADDR_W = BANK_W + 2*DATA_W;

  logic [3:0]        sel, sel_q, enter;
  logic [DATA_W-1:0] hi_q, lo_q, wd_q;
  logic              wr_q;

  always_comb begin
    sel = '0;
    if (!host_busreq_n) sel[mode] = 1'b1;
  end

  assign enter = sel & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      wd_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      sel_q <= sel;
      wr_q  <= enter[2];
      if (enter[0]) hi_q <= host_data;
      if (enter[1]) lo_q <= host_data;
      if (enter[2]) wd_q <= host_data;
    end
  end

  assign target_busreq_n = host_busreq_n;
  assign target_reset_n  = ~host_reset;
  assign sram_bus_oe     = ~target_busack_n;
  assign sram_addr       = sram_bus_oe ? {host_bank, hi_q, lo_q} : '0;
  assign sram_wdata      = sram_bus_oe ? wd_q : '0;
  assign sram_ce_n       = ~sram_bus_oe;
  assign sram_we_n       = ~(sram_bus_oe & wr_q);

  logic unused_w;
  assign unused_w = ^{enter[3], ADDR_W[0]};
endmodule

// File: rtl/host_sram_loader_chk.sv
module host_sram_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        host_busreq_n,
  input logic        target_busack_n,
  input logic        sram_bus_oe,
  input logic [16:0] sram_addr,
  input logic        sram_ce_n,
  input logic        sram_we_n
);
  assert_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    target_busack_n |-> (!sram_bus_oe && sram_we_n && sram_ce_n && sram_addr == '0));

  assert_one_cycle_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);

  assert_write_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(rst_n)) |-> ($past(mode) == 2'b10 && !$past(host_busreq_n)));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busreq_n && !target_busack_n) |=>
      (target_busack_n || sram_addr[15:0] == $past(sram_addr[15:0])));
endmodule

bind host_sram_loader host_sram_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .host_busreq_n(host_busreq_n),
  .target_busack_n(target_busack_n), .sram_bus_oe(sram_bus_oe),
  .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n)
);

// File: tb/host_sram_loader_tb_top.sv
module host_sram_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data = '0;
  logic [1:0]  mode = 2'b11;
  logic        host_busreq_n = 1'b1;
  logic        host_bank = 1'b0;
  logic        host_reset = 1'b1;
  logic        target_busack_n = 1'b1;
  logic        target_busreq_n, target_reset_n, sram_bus_oe, sram_ce_n, sram_we_n;
  logic [16:0] sram_addr;
  logic [7:0]  sram_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  host_sram_loader dut_i (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .mode(mode),
    .host_busreq_n(host_busreq_n), .host_bank(host_bank), .host_reset(host_reset),
    .target_busack_n(target_busack_n), .target_busreq_n(target_busreq_n),
    .target_reset_n(target_reset_n), .sram_bus_oe(sram_bus_oe), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [7:0] d);
    @(negedge clk);
    mode = m;
    host_data = d;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 we_n in reset", 32'(sram_we_n), 1);
    chk("R8 oe in reset", 32'(sram_bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    target_busack_n = 1'b0;
    @(negedge clk);
    chk("R1 address after reset", 32'(sram_addr), 0);
    chk("R1 no write after reset", 32'(sram_we_n), 1);
  endtask

  task automatic t_grant;
    @(negedge clk);
    host_busreq_n = 1'b0;
    #1;
    chk("R11 busreq follows", 32'(target_busreq_n), 0);
    @(negedge clk);
    chk("R8 driven when acked", 32'({sram_bus_oe, sram_ce_n}), 32'b10);
  endtask

  task automatic t_high;
    step(2'b00, 8'h12);
    chk("R2 high byte", 32'(sram_addr[15:8]), 32'h12);
    step(2'b00, 8'h99);
    chk("R3 held mode no recapture", 32'(sram_addr[15:8]), 32'h12);
  endtask

  task automatic t_low_write;
    step(2'b01, 8'h34);
    chk("R6 low byte", 32'(sram_addr[15:0]), 32'h1234);
    step(2'b10, 8'hA5);
    chk("R4 we_n low", 32'(sram_we_n), 0);
    chk("R4 write data", 32'(sram_wdata), 32'hA5);
    chk("R4 write addr", 32'(sram_addr[15:0]), 32'h1234);
    step(2'b10, 8'h5A);
    chk("R5 single pulse", 32'(sram_we_n), 1);
    chk("R3 data held", 32'(sram_wdata), 32'hA5);
  endtask

  task automatic t_sector;
    for (int i = 0; i < 4; i++) begin
      step(2'b01, 8'(8'h40 + i));
      chk("R6 no write on addr load", 32'(sram_we_n), 1);
      step(2'b10, 8'(8'hC0 ^ i));
      chk("R6 sector we_n", 32'(sram_we_n), 0);
      chk("R6 sector addr", 32'(sram_addr[15:0]), 32'(16'h1240 + i));
      chk("R6 sector data", 32'(sram_wdata), 32'(8'hC0 ^ i));
    end
  endtask

  task automatic t_unused;
    step(2'b11, 8'hFF);
    chk("R10 no write", 32'(sram_we_n), 1);
    chk("R10 addr kept", 32'(sram_addr[15:0]), 32'h1243);
  endtask

  task automatic t_bank;
    @(negedge clk);
    host_bank = 1'b1;
    #1;
    chk("R9 bank bit set", 32'(sram_addr[16]), 1);
    host_bank = 1'b0;
    #1;
    chk("R9 bank bit clear", 32'(sram_addr[16]), 0);
    host_bank = 1'b1;
  endtask

  task automatic t_disabled;
    @(negedge clk);
    host_busreq_n = 1'b1;
    step(2'b00, 8'hEE);
    step(2'b01, 8'hDD);
    step(2'b10, 8'hCC);
    chk("R7 no write disabled", 32'(sram_we_n), 1);
    chk("R7 addr unchanged", 32'(sram_addr), 32'h11243);
    step(2'b11, 8'h00);
    @(negedge clk);
    host_busreq_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_release;
    @(negedge clk);
    target_busack_n = 1'b1;
    #1;
    chk("R8 oe off", 32'(sram_bus_oe), 0);
    chk("R8 addr floats", 32'(sram_addr), 0);
    chk("R8 ce off", 32'(sram_ce_n), 1);
    step(2'b10, 8'h77);
    chk("R8 no strobe unacked", 32'(sram_we_n), 1);
    chk("R8 data floats", 32'(sram_wdata), 0);
  endtask

  task automatic t_boot;
    step(2'b11, 8'h00);
    host_reset = 1'b1;
    #1;
    chk("R11 reset asserted", 32'(target_reset_n), 0);
    host_busreq_n = 1'b1;
    #1;
    chk("R11 busreq released", 32'(target_busreq_n), 1);
    @(negedge clk);
    host_reset = 1'b0;
    #1;
    chk("R11 reset released", 32'(target_reset_n), 1);
  endtask

  initial begin
    t_reset;
    t_grant;
    t_high;
    t_low_write;
    t_sector;
    t_unused;
    t_bank;
    t_disabled;
    t_release;
    t_boot;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule